// File: doc/BRIEF.md
# H-Bridge Command Decoder with Sleep Sequencing

This block converts a two-bit drive command into four gate enables for a full H-bridge: a high-side and a low-side enable for each of the two legs. Leg A is the output that goes high on a forward command; leg B is the other output. Both command inputs are synchronised, then filtered against short glitches. Every switch-on is preceded by a guaranteed interval in which both switches of that leg are off, so no leg can conduct straight through.

A power sequencer sits in front of the decoder. After reset the block is asleep. A command that holds either input high for a qualification window, followed by a turn-on delay, brings it to the running state, and the `ready` output is high only in that state. If the coast command persists in the running state for the idle window, the block returns to sleep. All time constants are given in nanoseconds and converted to clock ticks from the clock frequency parameter, rounding up to at least one tick.

Top module: `hbridge_cmd_dec`

## Requirements
- R1: Each input passes through two synchronising flops and then a filter. A new level is accepted only after the synchronised value has differed from the accepted value on FLT consecutive clocks, where FLT is half the tick count of MIN_PULSE_NS and at least 1. A shorter pulse is ignored. From an input edge to the first switch change it takes 3+FLT clock edges, provided the leg has already been off long enough.
- R2: While ready, the accepted pair {in_b,in_a} decodes as follows. 2'b00 is coast: all four enables are 0. 2'b01 is forward: hs_en=2'b01, ls_en=2'b10. 2'b10 is reverse: hs_en=2'b10, ls_en=2'b01. 2'b11 is brake: hs_en=2'b00, ls_en=2'b11. Bit 0 of each enable bus is leg A.
- R3: In no cycle does a leg have its high-side and low-side enables both at 1.
- R4: A switch turns on only after both switches of its leg have been off for at least DEAD ticks. On a direct reversal of a leg, that off interval is exactly DEAD cycles, and a leg whose target does not change is left undisturbed.
- R5: Synchronous active-high reset puts the block into sleep with ready=0 and all enables 0, whatever the inputs are. No idle wait takes place first.
- R6: From sleep, if either accepted input stays high for QUAL ticks and then TON more ticks pass, ready rises. This is 3+FLT+QUAL+TON clock edges after the input edge.
- R7: If both accepted inputs return low before qualification completes, the block goes back to sleep and ready stays 0.
- R8: While ready is 0, all four enables are 0.
- R9: In the running state, the coast command held for IDLE ticks returns the block to sleep, so ready falls 2+FLT+IDLE edges after the inputs go low. Any accepted high input restarts this count.
- R10: Tick counts are computed as ceil(ns × CLK_KHZ / 10^6), with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_a | input | 1 | Command bit A (forward when alone) |
| in_b | input | 1 | Command bit B (reverse when alone) |
| hs_en | output | 2 | High-side enables, bit 0 = leg A |
| ls_en | output | 2 | Low-side enables, bit 0 = leg A |
| ready | output | 1 | Bridge is running and decoding commands |

## Verification
The bound checker asserts on every cycle that no leg ever has both switches on, that every switch-on comes after at least the dead interval with the leg off, that all switches are off whenever ready is low, and that ready never rises before the qualification and turn-on windows have elapsed. Some properties can only be shown by the bench scenarios, because they depend on exact cycle counts and input history: the decode table itself, the exact synchroniser and filter latency, the rejection of a pulse one cycle shorter than the filter, the exact dead interval on a reversal, aborting qualification, and the timing of the idle timeout together with its restart.

// File: rtl/hb_pkg.sv
`timescale 1ns/1ps
package hb_pkg;

  typedef enum logic [1:0] {LEG_OFF, LEG_HI, LEG_LO} leg_t;

  typedef enum logic [1:0] {PWR_SLEEP, PWR_QUAL, PWR_WAKE, PWR_RUN} pwr_t;

  // Round a duration up to whole clock ticks, never less than one.
  function automatic int ns_to_ticks(input longint ns, input longint khz);
    longint t;
    t = (ns * khz + 64'd999_999) / 64'd1_000_000;
    if (t < 1) t = 1;
    return int'(t);
  endfunction

endpackage

// File: rtl/hb_in_filter.sv
`timescale 1ns/1ps
module hb_in_filter #(
  parameter int FLT_TICKS = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FLT_TICKS + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      run_q  <= '0;
      dout   <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], din};
      if (sync_q[1] == dout) begin
        run_q <= '0;
      end else if (run_q == CW'(FLT_TICKS - 1)) begin
        dout  <= sync_q[1];
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hb_power_seq.sv
`timescale 1ns/1ps
module hb_power_seq
  import hb_pkg::*;
#(
  parameter int IDLE_TICKS = 4,
  parameter int QUAL_TICKS = 2,
  parameter int TON_TICKS  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic any_hi,
  output logic ready
);
  localparam int MAXT = (IDLE_TICKS > QUAL_TICKS) ?
                        ((IDLE_TICKS > TON_TICKS) ? IDLE_TICKS : TON_TICKS) :
                        ((QUAL_TICKS > TON_TICKS) ? QUAL_TICKS : TON_TICKS);
  localparam int CW = $clog2(MAXT + 1);

  pwr_t          state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PWR_SLEEP;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        PWR_SLEEP: begin
          cnt_q <= '0;
          if (any_hi) state_q <= PWR_QUAL;
        end
        PWR_QUAL: begin
          if (!any_hi) begin
            state_q <= PWR_SLEEP;
            cnt_q   <= '0;
          end else if (cnt_q == CW'(QUAL_TICKS - 1)) begin
            state_q <= PWR_WAKE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PWR_WAKE: begin
          if (cnt_q == CW'(TON_TICKS - 1)) begin
            state_q <= PWR_RUN;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          if (any_hi) begin
            cnt_q <= '0;
          end else if (cnt_q == CW'(IDLE_TICKS - 1)) begin
            state_q <= PWR_SLEEP;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign ready = (state_q == PWR_RUN);
endmodule

// File: rtl/hb_leg_drive.sv
`timescale 1ns/1ps
module hb_leg_drive
  import hb_pkg::*;
#(
  parameter int DEAD_TICKS = 1
) (
  input  logic clk,
  input  logic rst,
  input  leg_t tgt,
  output logic hs,
  output logic ls
);
  localparam int CW = $clog2(DEAD_TICKS + 1);

  logic [CW-1:0] off_q;
  logic          both_off;
  logic          gap_ok;

  assign both_off = !hs && !ls;
  assign gap_ok   = both_off && (off_q >= CW'(DEAD_TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hs    <= 1'b0;
      ls    <= 1'b0;
      off_q <= '0;
    end else begin
      if (!both_off)                       off_q <= '0;
      else if (off_q != CW'(DEAD_TICKS))   off_q <= off_q + 1'b1;

      case (tgt)
        LEG_HI: begin
          if (ls)          ls <= 1'b0;
          else if (gap_ok) hs <= 1'b1;
        end
        LEG_LO: begin
          if (hs)          hs <= 1'b0;
          else if (gap_ok) ls <= 1'b1;
        end
        default: begin
          hs <= 1'b0;
          ls <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/hbridge_cmd_dec.sv
`timescale 1ns/1ps
module hbridge_cmd_dec
  import hb_pkg::*;
#(
  parameter int CLK_KHZ      = 250_000,
  parameter int IDLE_NS      = 1_000_000,
  parameter int QUAL_NS      = 5_000,
  parameter int TON_NS       = 50_000,
  parameter int DEAD_NS      = 250,
  parameter int MIN_PULSE_NS = 800
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_a,
  input  logic       in_b,
  output logic [1:0] hs_en,
  output logic [1:0] ls_en,
  output logic       ready
);
  localparam int NLEG       = 2;
  localparam int IDLE_TICKS = ns_to_ticks(IDLE_NS, CLK_KHZ);
  localparam int QUAL_TICKS = ns_to_ticks(QUAL_NS, CLK_KHZ);
  localparam int TON_TICKS  = ns_to_ticks(TON_NS, CLK_KHZ);
  localparam int DEAD_TICKS = ns_to_ticks(DEAD_NS, CLK_KHZ);
  localparam int PULSE_T    = ns_to_ticks(MIN_PULSE_NS, CLK_KHZ);
  localparam int FLT_TICKS  = (PULSE_T / 2 < 1) ? 1 : PULSE_T / 2;

  logic [NLEG-1:0] raw_in;
  logic [NLEG-1:0] acc_in;
  leg_t            tgt [NLEG];

  assign raw_in = {in_b, in_a};

  for (genvar i = 0; i < NLEG; i++) begin : g_in
    hb_in_filter #(.FLT_TICKS(FLT_TICKS)) u_flt (
      .clk (clk),
      .rst (rst),
      .din (raw_in[i]),
      .dout(acc_in[i])
    );
  end

  hb_power_seq #(
    .IDLE_TICKS(IDLE_TICKS),
    .QUAL_TICKS(QUAL_TICKS),
    .TON_TICKS (TON_TICKS)
  ) u_pwr (
    .clk   (clk),
    .rst   (rst),
    .any_hi(|acc_in),
    .ready (ready)
  );

  always_comb begin
    tgt[0] = LEG_OFF;
    tgt[1] = LEG_OFF;
    if (ready) begin
      case (acc_in)
        2'b01:   begin tgt[0] = LEG_HI; tgt[1] = LEG_LO; end
        2'b10:   begin tgt[0] = LEG_LO; tgt[1] = LEG_HI; end
        2'b11:   begin tgt[0] = LEG_LO; tgt[1] = LEG_LO; end
        default: begin tgt[0] = LEG_OFF; tgt[1] = LEG_OFF; end
      endcase
    end
  end

  for (genvar g = 0; g < NLEG; g++) begin : g_leg
    hb_leg_drive #(.DEAD_TICKS(DEAD_TICKS)) u_leg (
      .clk(clk),
      .rst(rst),
      .tgt(tgt[g]),
      .hs (hs_en[g]),
      .ls (ls_en[g])
    );
  end
endmodule

// File: rtl/hb_checker.sv
`timescale 1ns/1ps
module hb_checker
  import hb_pkg::*;
#(
  parameter int CLK_KHZ = 250_000,
  parameter int QUAL_NS = 5_000,
  parameter int TON_NS  = 50_000,
  parameter int DEAD_NS = 250
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] hs_en,
  input logic [1:0] ls_en,
  input logic       ready
);
  localparam int DEAD_T = ns_to_ticks(DEAD_NS, CLK_KHZ);
  localparam int WAKE_T = ns_to_ticks(QUAL_NS, CLK_KHZ) + ns_to_ticks(TON_NS, CLK_KHZ);

  int low_run;
  always_ff @(posedge clk) begin
    if (rst || ready)         low_run <= 0;
    else if (low_run < WAKE_T) low_run <= low_run + 1;
  end

  for (genvar g = 0; g < 2; g++) begin : g_chk
    int off_run;
    always_ff @(posedge clk) begin
      if (rst || hs_en[g] || ls_en[g]) off_run <= 0;
      else if (off_run < DEAD_T)       off_run <= off_run + 1;
    end

    assert_no_shoot_R3: assert property (@(posedge clk) disable iff (rst)
      !(hs_en[g] && ls_en[g]));

    assert_dead_gap_R4: assert property (@(posedge clk) disable iff (rst)
      ($rose(hs_en[g]) || $rose(ls_en[g])) |-> (off_run >= DEAD_T));
  end

  assert_off_unless_ready_R8: assert property (@(posedge clk) disable iff (rst)
    !ready |-> (hs_en == 2'b00 && ls_en == 2'b00));

  assert_wake_delay_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (low_run >= WAKE_T));
endmodule

bind hbridge_cmd_dec hb_checker #(
  .CLK_KHZ(CLK_KHZ),
  .QUAL_NS(QUAL_NS),
  .TON_NS (TON_NS),
  .DEAD_NS(DEAD_NS)
) u_hb_checker (
  .clk  (clk),
  .rst  (rst),
  .hs_en(hs_en),
  .ls_en(ls_en),
  .ready(ready)
);

// File: tb/hbridge_cmd_dec_tb.sv
`timescale 1ns/1ps
module hbridge_cmd_dec_tb;
  localparam int KHZ = 10_000;

  function automatic int tk(input longint ns);
    longint t;
    t = (ns * KHZ + 999_999) / 1_000_000;
    return (t < 1) ? 1 : int'(t);
  endfunction

  // R10: tick derivation, computed here independently
  localparam int FLT  = (tk(800) / 2 < 1) ? 1 : tk(800) / 2;
  localparam int DEAD = tk(250);
  localparam int QUAL = tk(5_000);
  localparam int TON  = tk(50_000);
  localparam int IDLE = tk(1_000_000);
  localparam int WAKE_LAT = 3 + FLT + QUAL + TON;

  logic clk = 1'b0, rst = 1'b1, in_a = 1'b0, in_b = 1'b0;
  logic [1:0] hs_en, ls_en;
  logic ready;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hbridge_cmd_dec #(.CLK_KHZ(KHZ)) u_dut (
    .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b),
    .hs_en(hs_en), .ls_en(ls_en), .ready(ready)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_out(input logic [1:0] h, input logic [1:0] l, input string req);
    check(hs_en == h && ls_en == l, req, {hs_en, ls_en}, {h, l});
  endtask

  task automatic gap_run(output int offa, output int offb, output int shoot, output int bdrop);
    offa = 0; offb = 0; shoot = 0; bdrop = 0;
    for (int k = 0; k < 40; k++) begin
      cyc(1);
      if (!hs_en[0] && !ls_en[0]) offa++;
      if (!hs_en[1] && !ls_en[1]) offb++;
      if ((hs_en & ls_en) != 2'b00) shoot++;
      if (!ls_en[1]) bdrop++;
    end
  endtask

  initial begin
    #600_000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int n, oa, ob, sh, bd;
    bit seen;
    // R5: reset state with inputs high
    in_a = 1; in_b = 1;
    cyc(5);
    chk_out(2'b00, 2'b00, "R5 outputs in reset");
    check(ready == 0, "R5 ready in reset", ready, 0);
    rst = 0;
    cyc(WAKE_LAT - 1);
    check(ready == 0, "R6 ready one edge early", ready, 0);
    cyc(1);
    check(ready == 1, "R6 ready at wake latency", ready, 1);
    cyc(5);
    chk_out(2'b00, 2'b11, "R2 brake");

    // R2: decode sweep
    in_a = 1; in_b = 0; cyc(30); chk_out(2'b01, 2'b10, "R2 forward");
    in_a = 0; in_b = 1; cyc(30); chk_out(2'b10, 2'b01, "R2 reverse");
    in_a = 0; in_b = 0; cyc(30); chk_out(2'b00, 2'b00, "R2 coast");
    check(ready == 1, "R9 still ready after short coast", ready, 1);

    // R1: coast -> forward latency
    in_a = 1; n = 0;
    while (!hs_en[0] && n < 100) begin cyc(1); n++; end
    check(n == 3 + FLT, "R1 input to switch latency", n, 3 + FLT);
    cyc(30);

    // R4/R3: forward -> reverse
    in_a = 0; in_b = 1;
    gap_run(oa, ob, sh, bd);
    check(oa == DEAD, "R4 leg A reversal gap", oa, DEAD);
    check(ob == DEAD, "R4 leg B reversal gap", ob, DEAD);
    check(sh == 0, "R3 no shoot-through", sh, 0);
    chk_out(2'b10, 2'b01, "R2 reverse after gap");

    // R4: brake -> forward, leg B untouched
    in_a = 1; in_b = 1; cyc(30);
    in_b = 0;
    gap_run(oa, ob, sh, bd);
    check(oa == DEAD, "R4 leg A brake to forward gap", oa, DEAD);
    check(bd == 0, "R4 leg B undisturbed", bd, 0);

    // R1: glitch rejection from coast
    in_a = 0; in_b = 0; cyc(30);
    in_a = 1; cyc(FLT - 1); in_a = 0;
    seen = 0;
    for (int k = 0; k < 30; k++) begin cyc(1); if (hs_en != 0 || ls_en != 0) seen = 1; end
    check(!seen, "R1 short pulse ignored", seen, 0);
    in_a = 1; cyc(2 * FLT); in_a = 0;
    seen = 0;
    for (int k = 0; k < 30; k++) begin cyc(1); if (hs_en[0]) seen = 1; end
    check(seen, "R1 minimum pulse accepted", seen, 1);

    // R9: idle timeout and restart
    in_a = 1; in_b = 1; cyc(30);
    in_a = 0; in_b = 0; cyc(5000);
    in_a = 1; in_b = 1; cyc(30);
    in_a = 0; in_b = 0; n = 0;
    while (ready && n < 20000) begin cyc(1); n++; end
    check(n == 2 + FLT + IDLE, "R9 idle timeout after restart", n, 2 + FLT + IDLE);
    chk_out(2'b00, 2'b00, "R8 outputs off in sleep");

    // R7: aborted qualification
    in_a = 1; in_b = 1; cyc(QUAL / 2); in_a = 0; in_b = 0;
    seen = 0;
    for (int k = 0; k < QUAL + TON + 100; k++) begin cyc(1); if (ready || hs_en != 0 || ls_en != 0) seen = 1; end
    check(!seen, "R7 abort keeps sleep", seen, 0);

    // R6: wake after abort
    in_a = 1; cyc(WAKE_LAT - 1);
    check(ready == 0, "R6 ready early after abort", ready, 0);
    cyc(1);
    check(ready == 1, "R6 ready after abort", ready, 1);
    cyc(5);
    chk_out(2'b01, 2'b10, "R2 forward after wake");

    // R5: reset with inputs low goes straight to sleep
    rst = 1; in_a = 0; in_b = 0; cyc(3); rst = 0;
    cyc(20);
    check(ready == 0, "R5 asleep after reset low", ready, 0);
    chk_out(2'b00, 2'b00, "R5 outputs after reset low");
    in_b = 1; cyc(WAKE_LAT - 1);
    check(ready == 0, "R5 no idle wait before sleep", ready, 0);
    cyc(1);
    check(ready == 1, "R5 wake from immediate sleep", ready, 1);
    cyc(5);
    chk_out(2'b10, 2'b01, "R2 reverse after reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule